// File: doc/BRIEF.md
# I2C Master with Address Acknowledge Polling

This block is a single-master I2C controller. It drives SCL and SDA as open-drain lines through pull-low enables and runs a complete transfer from one command. A command carries a 7-bit target address, a direction flag, a byte count and a flag that asks for a STOP at the end. The controller generates START, sends the address byte, and then either takes bytes from a write-data handshake or delivers received bytes on a read-data handshake. A single-cycle `done` pulse reports the result together with an error vector.

If the target does not acknowledge its address, the controller finishes with STOP and then retries START plus address. It keeps doing this until the target acknowledges or a cycle budget counted from command acceptance runs out. This suits memories that stop responding while an internal write is in progress. Once the START has been driven, SDA is read back; if it is still high, the bus is treated as lost. Any error on a data byte forces an immediate STOP. Timing comes from a half-bit period given in system clock cycles.

The controller is a state machine with these states:

- `S_IDLE` waits for a command and moves to `S_STA_REL`.
- `S_STA_REL` releases both lines for a half bit and moves to `S_STA_LOW`.
- `S_STA_LOW` pulls SDA low for a half bit. It moves to `S_WR_LO`, or to `S_STP_LO` if SDA reads high.
- `S_WR_LO` and `S_WR_HI` are the SCL low and high halves of one transmitted bit. After nine bits they move to `S_ACK_LO`.
- `S_ACK_LO` is the SCL-low half bit after the acknowledge. It moves to `S_LOAD`, `S_RD_LO`, `S_STP_LO` or `S_FIN`.
- `S_LOAD` holds SCL low until write data arrives, then moves to `S_WR_LO`.
- `S_RD_LO` and `S_RD_HI` are the two halves of one received bit. After eight bits they move to `S_PUSH`.
- `S_PUSH` holds SCL low until the read byte is taken, then moves to `S_MACK_LO`.
- `S_MACK_LO` and `S_MACK_HI` are the two halves of the master acknowledge. They then move to `S_RD_LO`, `S_STP_LO` or `S_FIN`.
- `S_STP_LO` pulls both lines low, then `S_STP_HI` releases SCL. From there the machine moves to `S_STA_REL` for a retry, or to `S_FIN`.
- `S_FIN` releases both lines, pulses `done` and returns to `S_IDLE`.

Top module: `i2c_poll_master`

## Requirements
- R1: After reset, and whenever `cmd_ready` is high, both `scl_oe` and `sda_oe` are 0 (lines released) and `cmd_ready` is 1.
- R2: Each attempt starts with SDA falling while SCL is high. It then sends the address byte MSB first as {addr[6:0], rw}, where rw=1 means read and rw=0 means write, followed by a ninth bit with SDA released.
- R3: Every SCL high phase during a transmitted or received bit lasts exactly HALF_CYC clock cycles.
- R4: For a write, exactly `cmd_len` bytes are taken over `wr_valid`/`wr_ready` and sent MSB first, each followed by a released acknowledge bit.
- R5: For a read, `cmd_len` bytes are sampled MSB first and held on `rd_data` with `rd_valid` until `rd_ready`. The master drives ACK (SDA low) after every byte except the last, and NACK (SDA released) after the last.
- R6: After the last byte, a STOP (SDA rising while SCL is high) is produced only when `cmd_stop` was set.
- R7: An address NACK is followed by STOP and a new START plus address, repeated until the address is acknowledged.
- R8: `err` bit 0 is no-acknowledge, bit 1 is bus lost and bit 2 is start timeout. If the address is still refused once more than TIMEOUT_CYC cycles have passed since command acceptance, the transfer ends with STOP and `err`=3'b101.
- R9: A NACK on a write data byte sets `err`=3'b001, forces STOP, and requests no further write bytes.
- R10: If SDA reads high at the end of the START, `err`=3'b010, STOP follows and no byte is sent.
- R11: `done` is high for exactly one cycle per command, and `cmd_ready` stays low from command acceptance until `done`.
- R12: The no-acknowledge and bus-lost bits are cleared at each START attempt, so a retry that succeeds ends with `err`=3'b000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Controller idle, command accepted |
| cmd_addr | input | 7 | Target address |
| cmd_rd | input | 1 | 1 = read, 0 = write |
| cmd_len | input | CNT_W | Number of data bytes |
| cmd_stop | input | 1 | Issue STOP after the last byte |
| wr_data | input | 8 | Write byte |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Write byte accepted |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | Received byte available |
| rd_ready | input | 1 | Received byte taken |
| done | output | 1 | One-cycle end-of-command pulse |
| err | output | 3 | Error vector, valid with `done` |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_in | input | 1 | SDA line level (asynchronous) |

## Verification
The bench attaches a target model to the open-drain bus and covers six corner cases.

- **Address NACKed a few times, then acknowledged.** A design that does not retry ends with an error. A design that does not clear the acknowledge bit on each attempt reports a stale no-acknowledge.
- **Address that is never acknowledged.** A design with a broken timeout hangs, or returns without the timeout bit.
- **NACK on a middle write byte.** A design that does not abort asks for extra bytes or skips the STOP.
- **SDA stuck high.** This checks that the bus-lost path sends no byte.
- **Reads of various lengths.** A controller that takes its ACK/NACK choice from the wrong count acknowledges the final byte.
- **Commands without the STOP flag, and zero-length commands.** A design that gets these wrong emits spurious STOPs.

// File: rtl/i2c_pm_pkg.sv
package i2c_pm_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_STA_REL,
        S_STA_LOW,
        S_WR_LO,
        S_WR_HI,
        S_ACK_LO,
        S_LOAD,
        S_RD_LO,
        S_RD_HI,
        S_PUSH,
        S_MACK_LO,
        S_MACK_HI,
        S_STP_LO,
        S_STP_HI,
        S_FIN
    } pm_state_t;

    localparam int ERR_W     = 3;
    localparam int ERR_NOACK = 0;
    localparam int ERR_ARB   = 1;
    localparam int ERR_TMO   = 2;

endpackage

// File: rtl/i2c_pm_sync.sv
module i2c_pm_sync #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            dout   <= RST_VAL;
        end else begin
            meta_q <= din;
            dout   <= meta_q;
        end
    end
endmodule

// File: rtl/i2c_pm_halfbit.sv
module i2c_pm_halfbit #(
    parameter int HALF_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    localparam int CW = $clog2(HALF_CYC + 1);

    logic [CW-1:0] cnt_q;

    assign expire = run && (cnt_q == CW'(HALF_CYC - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run || expire)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/i2c_pm_watch.sv
module i2c_pm_watch #(
    parameter int TIMEOUT_CYC = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic expired
);
    localparam int CW = $clog2(TIMEOUT_CYC + 2);

    logic [CW-1:0] cnt_q;

    assign expired = (cnt_q > CW'(TIMEOUT_CYC));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clear)
            cnt_q <= '0;
        else if (!expired)
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/i2c_poll_master.sv
module i2c_poll_master
    import i2c_pm_pkg::*;
#(
    parameter int HALF_CYC    = 8,
    parameter int TIMEOUT_CYC = 2000,
    parameter int CNT_W       = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [6:0]       cmd_addr,
    input  logic             cmd_rd,
    input  logic [CNT_W-1:0] cmd_len,
    input  logic             cmd_stop,
    input  logic [7:0]       wr_data,
    input  logic             wr_valid,
    output logic             wr_ready,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    input  logic             rd_ready,
    output logic             done,
    output logic [2:0]       err,
    output logic             scl_oe,
    output logic             sda_oe,
    input  logic             sda_in
);
    localparam int LAST_WBIT = 8;
    localparam int LAST_RBIT = 7;

    pm_state_t        state_q, state_d;
    logic             hb_run, hb_exp, to_exp, sda_s, cmd_take;

    logic [6:0]       addr_q;
    logic             rd_q, stop_q;
    logic [CNT_W-1:0] rem_q;
    logic [8:0]       sh_q;
    logic [7:0]       rdsh_q;
    logic [3:0]       bit_q;
    logic             addr_ph_q, nack_q, retry_q, ack_drv_q;
    logic [ERR_W-1:0] err_q;

    assign cmd_take = (state_q == S_IDLE) && cmd_valid;

    i2c_pm_sync #(.RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (sda_in),
        .dout  (sda_s)
    );

    i2c_pm_halfbit #(.HALF_CYC(HALF_CYC)) u_half (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (hb_run),
        .expire (hb_exp)
    );

    i2c_pm_watch #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_watch (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (cmd_take),
        .expired (to_exp)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (cmd_valid) state_d = S_STA_REL;
            S_STA_REL: if (hb_exp) state_d = S_STA_LOW;
            S_STA_LOW: if (hb_exp) state_d = sda_s ? S_STP_LO : S_WR_LO;
            S_WR_LO:   if (hb_exp) state_d = S_WR_HI;
            S_WR_HI:   if (hb_exp) state_d = (bit_q == 4'(LAST_WBIT)) ? S_ACK_LO : S_WR_LO;
            S_ACK_LO: begin
                if (hb_exp) begin
                    if (nack_q)
                        state_d = S_STP_LO;
                    else if (rem_q == '0)
                        state_d = stop_q ? S_STP_LO : S_FIN;
                    else if (addr_ph_q && rd_q)
                        state_d = S_RD_LO;
                    else
                        state_d = S_LOAD;
                end
            end
            S_LOAD:    if (wr_valid) state_d = S_WR_LO;
            S_RD_LO:   if (hb_exp) state_d = S_RD_HI;
            S_RD_HI:   if (hb_exp) state_d = (bit_q == 4'(LAST_RBIT)) ? S_PUSH : S_RD_LO;
            S_PUSH:    if (rd_ready) state_d = S_MACK_LO;
            S_MACK_LO: if (hb_exp) state_d = S_MACK_HI;
            S_MACK_HI: begin
                if (hb_exp) begin
                    if (rem_q == '0)
                        state_d = stop_q ? S_STP_LO : S_FIN;
                    else
                        state_d = S_RD_LO;
                end
            end
            S_STP_LO:  if (hb_exp) state_d = S_STP_HI;
            S_STP_HI:  if (hb_exp) state_d = retry_q ? S_STA_REL : S_FIN;
            S_FIN:     state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        scl_oe    = 1'b0;
        sda_oe    = 1'b0;
        hb_run    = 1'b0;
        cmd_ready = 1'b0;
        wr_ready  = 1'b0;
        rd_valid  = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            S_IDLE:    cmd_ready = 1'b1;
            S_STA_REL: hb_run = 1'b1;
            S_STA_LOW: begin sda_oe = 1'b1; hb_run = 1'b1; end
            S_WR_LO:   begin scl_oe = 1'b1; sda_oe = ~sh_q[8]; hb_run = 1'b1; end
            S_WR_HI:   begin sda_oe = ~sh_q[8]; hb_run = 1'b1; end
            S_ACK_LO:  begin scl_oe = 1'b1; hb_run = 1'b1; end
            S_LOAD:    begin scl_oe = 1'b1; wr_ready = 1'b1; end
            S_RD_LO:   begin scl_oe = 1'b1; hb_run = 1'b1; end
            S_RD_HI:   hb_run = 1'b1;
            S_PUSH:    begin scl_oe = 1'b1; rd_valid = 1'b1; end
            S_MACK_LO: begin scl_oe = 1'b1; sda_oe = ack_drv_q; hb_run = 1'b1; end
            S_MACK_HI: begin sda_oe = ack_drv_q; hb_run = 1'b1; end
            S_STP_LO:  begin scl_oe = 1'b1; sda_oe = 1'b1; hb_run = 1'b1; end
            S_STP_HI:  begin sda_oe = 1'b1; hb_run = 1'b1; end
            S_FIN:     done = 1'b1;
            default:   ;
        endcase
    end

    assign rd_data = rdsh_q;
    assign err     = err_q;

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q    <= '0;
            rd_q      <= 1'b0;
            stop_q    <= 1'b0;
            rem_q     <= '0;
            sh_q      <= '1;
            rdsh_q    <= '0;
            bit_q     <= '0;
            addr_ph_q <= 1'b0;
            nack_q    <= 1'b0;
            retry_q   <= 1'b0;
            ack_drv_q <= 1'b0;
            err_q     <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (cmd_valid) begin
                        addr_q  <= cmd_addr;
                        rd_q    <= cmd_rd;
                        stop_q  <= cmd_stop;
                        rem_q   <= cmd_len;
                        err_q   <= '0;
                        retry_q <= 1'b0;
                    end
                end
                S_STA_REL: begin
                    err_q[ERR_NOACK] <= 1'b0;
                    err_q[ERR_ARB]   <= 1'b0;
                    retry_q          <= 1'b0;
                    addr_ph_q        <= 1'b1;
                end
                S_STA_LOW: begin
                    if (hb_exp) begin
                        if (sda_s)
                            err_q[ERR_ARB] <= 1'b1;
                        else begin
                            sh_q  <= {addr_q, rd_q, 1'b1};
                            bit_q <= '0;
                        end
                    end
                end
                S_WR_HI: begin
                    if (hb_exp) begin
                        if (bit_q == 4'(LAST_WBIT))
                            nack_q <= sda_s;
                        else begin
                            sh_q  <= {sh_q[7:0], 1'b1};
                            bit_q <= bit_q + 1'b1;
                        end
                    end
                end
                S_ACK_LO: begin
                    if (hb_exp) begin
                        bit_q <= '0;
                        if (nack_q) begin
                            err_q[ERR_NOACK] <= 1'b1;
                            if (addr_ph_q) begin
                                if (to_exp)
                                    err_q[ERR_TMO] <= 1'b1;
                                else
                                    retry_q <= 1'b1;
                            end
                        end else begin
                            addr_ph_q <= 1'b0;
                        end
                    end
                end
                S_LOAD: begin
                    if (wr_valid) begin
                        sh_q  <= {wr_data, 1'b1};
                        bit_q <= '0;
                        rem_q <= rem_q - 1'b1;
                    end
                end
                S_RD_HI: begin
                    if (hb_exp) begin
                        rdsh_q <= {rdsh_q[6:0], sda_s};
                        bit_q  <= bit_q + 1'b1;
                    end
                end
                S_PUSH: begin
                    if (rd_ready) begin
                        rem_q     <= rem_q - 1'b1;
                        ack_drv_q <= (rem_q > CNT_W'(1));
                        bit_q     <= '0;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/i2c_poll_master_chk.sv
module i2c_poll_master_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic       cmd_ready,
    input logic       wr_ready,
    input logic       rd_valid,
    input logic       rd_ready,
    input logic [7:0] rd_data,
    input logic       done,
    input logic [2:0] err,
    input logic       scl_oe,
    input logic       sda_oe
);
    assert_idle_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (!scl_oe && !sda_oe));

    assert_busy_after_take_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_tmo_with_noack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err[2]) |-> err[0]);

    assert_arb_alone_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err[1]) |-> (!err[0] && !err[2]));

    assert_rd_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

    assert_rd_scl_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> scl_oe);

    assert_hs_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_ready, wr_ready, rd_valid, done}));
endmodule

bind i2c_poll_master i2c_poll_master_chk u_chk (.*);

// File: tb/i2c_poll_master_tb.sv
`timescale 1ns/1ps
module i2c_poll_master_tb;
    localparam int HALF = 4;
    localparam int TMO  = 600;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0, cmd_ready, cmd_rd = 1'b0, cmd_stop = 1'b0;
    logic [6:0] cmd_addr = '0;
    logic [7:0] cmd_len = '0;
    logic [7:0] wr_data = '0, rd_data;
    logic       wr_valid = 1'b0, wr_ready, rd_valid, rd_ready = 1'b0, done;
    logic [2:0] err;
    logic       scl_oe, sda_oe, scl, sda, s_pull = 1'b0, force_hi = 1'b0;

    assign scl = !scl_oe;
    assign sda = force_hi ? 1'b1 : !(sda_oe || s_pull);

    always #10 clk = ~clk;

    i2c_poll_master #(.HALF_CYC(HALF), .TIMEOUT_CYC(TMO), .CNT_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_addr(cmd_addr), .cmd_rd(cmd_rd), .cmd_len(cmd_len), .cmd_stop(cmd_stop),
        .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
        .done(done), .err(err), .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda));

    int checks = 0, errors = 0;

    // target model state
    int nack_left = 0, nack_at = -1;
    int starts = 0, stops = 0, bitn = 0, idx = 0, wn = 0, mn = 0;
    int hi_cnt = 0, hi_min = 1000, hi_max = 0;
    logic prev_scl = 1'b1, prev_sda = 1'b1, in_x = 1'b0, is_addr = 1'b0;
    logic s_rw = 1'b0, s_tx = 1'b0, acked = 1'b0, rise_seen = 1'b0, sda_now;
    logic [7:0] shreg = '0, txb = '0, addr_seen = '0;
    logic [7:0] wlog [16];
    logic       mack [16];
    logic [7:0] rmem [16];
    logic [7:0] wq   [16];
    logic [7:0] rq   [16];
    int rn = 0, wreq = 0, busy_viol = 0;
    logic [2:0] res_err = '0;
    logic done_after = 1'b0;

    always @(negedge clk) begin
        if (!rst_n) begin
            prev_scl = 1'b1; prev_sda = 1'b1; in_x = 1'b0; s_pull = 1'b0; s_tx = 1'b0;
        end else begin
            sda_now = sda;
            if (scl) hi_cnt++;
            if (scl && prev_scl && prev_sda && !sda_now) begin
                starts++; in_x = 1'b1; bitn = 0; is_addr = 1'b1; s_tx = 1'b0;
                s_pull = 1'b0; rise_seen = 1'b0; idx = 0;
            end else if (scl && prev_scl && !prev_sda && sda_now) begin
                stops++; in_x = 1'b0; s_pull = 1'b0; s_tx = 1'b0;
            end else if (in_x && scl && !prev_scl) begin
                rise_seen = 1'b1; hi_cnt = 1;
                if (bitn < 8) begin
                    shreg = {shreg[6:0], sda_now}; bitn++;
                end else if (bitn == 8) begin
                    if (s_tx) begin
                        if (mn < 16) mack[mn] = !sda_now;
                        mn++;
                        if (sda_now) s_tx = 1'b0;
                    end
                    bitn = 9;
                end
            end else if (in_x && !scl && prev_scl) begin
                if (rise_seen) begin
                    if (hi_cnt < hi_min) hi_min = hi_cnt;
                    if (hi_cnt > hi_max) hi_max = hi_cnt;
                end
                rise_seen = 1'b0;
                if (bitn == 8) begin
                    if (s_tx) s_pull = 1'b0;
                    else if (is_addr) begin
                        addr_seen = shreg; s_rw = shreg[0];
                        if (nack_left > 0) begin nack_left--; s_pull = 1'b0; acked = 1'b0; end
                        else begin s_pull = 1'b1; acked = 1'b1; end
                    end else begin
                        if (wn < 16) wlog[wn] = shreg;
                        s_pull = (wn != nack_at);
                        wn++;
                    end
                end else if (bitn == 9) begin
                    bitn = 0; s_pull = 1'b0;
                    if (is_addr) begin
                        is_addr = 1'b0;
                        if (acked && s_rw) begin s_tx = 1'b1; txb = rmem[0]; end
                    end else if (s_tx) begin
                        idx++; txb = rmem[idx % 16];
                    end
                    if (s_tx) s_pull = !txb[7];
                end else if (s_tx && bitn < 8) begin
                    s_pull = !txb[7 - bitn];
                end
            end
            prev_scl = scl; prev_sda = sda_now;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic exp_mack(input int i, input int len);
        return (i < len - 1);
    endfunction

    function automatic logic [7:0] exp_addr(input logic [6:0] a, input logic rd);
        return {a, rd};
    endfunction

    task automatic run_cmd(input logic [6:0] a, input logic rd, input int len, input logic stp);
        logic took;
        wn = 0; mn = 0; rn = 0; wreq = 0; busy_viol = 0;
        hi_min = 1000; hi_max = 0;
        @(negedge clk);
        cmd_addr = a; cmd_rd = rd; cmd_len = len[7:0]; cmd_stop = stp; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0; wr_valid = 1'b1; took = 1'b0;
        while (1) begin
            if (took) begin wreq++; took = 1'b0; end
            wr_data = wq[wreq % 16];
            if (wr_ready) took = 1'b1;
            if (cmd_ready) busy_viol++;
            rd_ready = 1'($urandom % 2);
            if (rd_valid && rd_ready) begin
                if (rn < 16) rq[rn] = rd_data;
                rn++;
            end
            if (done) begin res_err = err; break; end
            @(negedge clk);
        end
        wr_valid = 1'b0; rd_ready = 1'b0;
        @(negedge clk);
        done_after = done;
    endtask

    task automatic fill(input int seed_mix);
        for (int i = 0; i < 16; i++) begin
            wq[i]   = 8'($urandom);
            rmem[i] = 8'($urandom ^ seed_mix);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int s0;
        void'($urandom(32'd1234));
        for (int i = 0; i < 16; i++) begin wlog[i] = '0; mack[i] = 1'b0; rq[i] = '0; end
        fill(0);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 cmd_ready", 32'(cmd_ready), 32'd1);
        chk("R1 scl_oe", 32'(scl_oe), 32'd0);
        chk("R1 sda_oe", 32'(sda_oe), 32'd0);
        chk("R11 done idle", 32'(done), 32'd0);

        // directed write of three bytes with STOP
        fill(1); s0 = stops;
        run_cmd(7'h50, 1'b0, 3, 1'b1);
        chk("R4 err", 32'(res_err), 32'd0);
        chk("R2 write addr byte", 32'(addr_seen), 32'(exp_addr(7'h50, 1'b0)));
        chk("R4 byte count", 32'(wn), 32'd3);
        for (int i = 0; i < 3; i++) chk("R4 write data", 32'(wlog[i]), 32'(wq[i]));
        chk("R6 stop issued", 32'(stops - s0), 32'd1);
        chk("R3 high min", 32'(hi_min), 32'(HALF));
        chk("R3 high max", 32'(hi_max), 32'(HALF));
        chk("R11 done one cycle", 32'(done_after), 32'd0);
        chk("R11 busy", 32'(busy_viol), 32'd0);

        // directed read of three bytes with STOP
        fill(2); s0 = stops;
        run_cmd(7'h2b, 1'b1, 3, 1'b1);
        chk("R5 err", 32'(res_err), 32'd0);
        chk("R2 read addr byte", 32'(addr_seen), 32'(exp_addr(7'h2b, 1'b1)));
        chk("R5 read count", 32'(rn), 32'd3);
        for (int i = 0; i < 3; i++) begin
            chk("R5 read data", 32'(rq[i]), 32'(rmem[i]));
            chk("R5 master ack", 32'(mack[i]), 32'(exp_mack(i, 3)));
        end
        chk("R6 stop after read", 32'(stops - s0), 32'd1);
        chk("R3 read high max", 32'(hi_max), 32'(HALF));

        // write without STOP, then a read with a repeated START
        fill(3); s0 = stops;
        run_cmd(7'h11, 1'b0, 2, 1'b0);
        chk("R6 no stop", 32'(stops - s0), 32'd0);
        chk("R4 nostop data", 32'(wlog[1]), 32'(wq[1]));
        run_cmd(7'h11, 1'b1, 1, 1'b0);
        chk("R5 single read", 32'(rq[0]), 32'(rmem[0]));
        chk("R5 single nack", 32'(mack[0]), 32'd0);
        chk("R6 no stop read", 32'(stops - s0), 32'd0);

        // address refused three times, then acknowledged
        fill(4); s0 = starts; nack_left = 3;
        run_cmd(7'h33, 1'b0, 2, 1'b1);
        chk("R7 start attempts", 32'(starts - s0), 32'd4);
        chk("R12 err cleared", 32'(res_err), 32'd0);
        chk("R7 data after retry", 32'(wlog[0]), 32'(wq[0]));

        // address never acknowledged: timeout
        nack_left = 1000000; s0 = starts;
        run_cmd(7'h44, 1'b0, 2, 1'b1);
        chk("R8 timeout err", 32'(res_err), 32'b101);
        chk("R8 several attempts", 32'(starts - s0 > 2), 32'd1);
        chk("R8 no data request", 32'(wreq), 32'd0);
        nack_left = 0;

        // NACK on the second write byte
        fill(5); nack_at = 1; s0 = stops;
        run_cmd(7'h5a, 1'b0, 4, 1'b0);
        chk("R9 err", 32'(res_err), 32'b001);
        chk("R9 bytes requested", 32'(wreq), 32'd2);
        chk("R9 forced stop", 32'(stops - s0), 32'd1);
        nack_at = -1;

        // zero-length write with STOP
        s0 = stops;
        run_cmd(7'h12, 1'b0, 0, 1'b1);
        chk("R4 zero len err", 32'(res_err), 32'd0);
        chk("R4 zero len requests", 32'(wreq), 32'd0);
        chk("R6 zero len stop", 32'(stops - s0), 32'd1);

        // constrained random transfers
        for (int t = 0; t < 16; t++) begin
            logic [6:0] a;
            logic       rd, stp;
            int         len;
            a = 7'($urandom); rd = 1'($urandom); stp = 1'($urandom);
            len = 1 + int'($urandom % 4);
            fill(t); s0 = stops;
            run_cmd(a, rd, len, stp);
            chk("R4 random err", 32'(res_err), 32'd0);
            chk("R2 random addr", 32'(addr_seen), 32'(exp_addr(a, rd)));
            chk("R6 random stop", 32'(stops - s0), 32'(stp));
            if (rd) begin
                for (int i = 0; i < len; i++) begin
                    chk("R5 random read", 32'(rq[i]), 32'(rmem[i]));
                    chk("R5 random ack", 32'(mack[i]), 32'(exp_mack(i, len)));
                end
            end else begin
                chk("R4 random count", 32'(wreq), 32'(len));
                for (int i = 0; i < len; i++) chk("R4 random write", 32'(wlog[i]), 32'(wq[i]));
            end
            chk("R3 random high", 32'(hi_max), 32'(HALF));
        end

        // SDA stuck high: bus lost
        force_hi = 1'b1;
        run_cmd(7'h21, 1'b0, 2, 1'b1);
        chk("R10 err", 32'(res_err), 32'b010);
        chk("R10 no data", 32'(wreq), 32'd0);
        force_hi = 1'b0;
        @(negedge clk);
        chk("R1 idle after", 32'({scl_oe, sda_oe, cmd_ready}), 32'b001);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule